// File: doc/BRIEF.md
# Memory Row Boundary Decoder

This block tells a memory controller which of its eight physical rows a given address falls in. Firmware programs each row's end point as a running total of installed memory, counted in 8 MB steps. The decoder compares the incoming address against all eight end points at once. It returns the lowest-numbered row whose end point lies above the address.

Two small per-row attributes are kept next to the boundaries and routed out with the selected row: a two-bit page-size code and a single bank-count flag. A row with no memory simply repeats the end point of the row before it. Such a row can never win the selection, so gaps in the population need no special handling.

The address-to-output path is purely combinational. The configuration registers are loaded through a small write port with synchronous, active-high reset. A write becomes visible on the clock edge that captures it.

Top module: `row_bound_decode`

## Requirements
- R1: Eight 8-bit boundary registers are loaded by a write with `wr_kind` = 0, using `wr_idx` as the row number and `wr_data[7:0]` as the value. Register n holds the size of rows 0..n together, in 8 MB units.
- R2: For an address A, the selected row is the lowest n with floor(A / 8 MB) < boundary n. `row_hit` is 1 and `row_idx` = n.
- R3: A row whose boundary equals the boundary of the row before it is never selected. Addresses in that range go to the next row whose boundary is larger.
- R4: When floor(A / 8 MB) is at or above every boundary, `row_hit` is 0 and `row_idx`, `page_code` and `bank_flag` are all 0.
- R5: `page_code` for selected row n is bits [2n+1:2n] of a 16-bit page word. The page word is loaded whole from `wr_data[15:0]` by a write with `wr_kind` = 1. Codes: 00 = 2 KB, 01 = 4 KB, 10 = 8 KB.
- R6: `bank_flag` for selected row n is bit n of a bank byte. The bank byte is loaded from `wr_data[7:0]` by a write with `wr_kind` = 2.
- R7: After reset, all boundaries, the page word and the bank byte are 0. Every address therefore misses, and every row defaults to the 2 KB page code 00.
- R8: A write with `wr_kind` = 3 changes no register.
- R9: The outputs follow a change of `addr` without waiting for a clock edge. A register write changes the outputs only after the clock edge that samples it.
- R10: A boundary of 255 is honoured in full: address 254 × 8 MB hits that row, and 255 × 8 MB misses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the configuration registers |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 32 | Physical byte address to decode |
| wr_en | input | 1 | Register write strobe |
| wr_kind | input | 2 | Write target: 0 boundary, 1 page word, 2 bank byte, 3 none |
| wr_idx | input | 3 | Row number for a boundary write |
| wr_data | input | 16 | Write data |
| row_idx | output | 3 | Selected row (0 on miss) |
| row_hit | output | 1 | Address lies below the last boundary |
| page_code | output | 2 | Page-size code of the selected row |
| bank_flag | output | 1 | Bank flag of the selected row |

## Verification
The hardest case to reach is a run of empty rows, where several boundaries are equal. The address must then skip every repeated row and land on the next populated one, while each skipped row still holds page and bank bits of its own.

The stimulus programs a layout with empty rows at the second, fifth and last positions. It gives the skipped rows page codes that differ from their neighbours, so a wrong pick shows up in the attributes as well as in the index. It then sweeps addresses at the first and last byte of each populated range.

A separate step loads the largest boundary value while the address is held fixed. The outputs are sampled on both sides of the capturing edge, which pins down when a write takes effect.

// File: rtl/rbd_pkg.sv
package rbd_pkg;
  typedef enum logic [1:0] {
    WK_BOUND = 2'd0,
    WK_PAGE  = 2'd1,
    WK_BANK  = 2'd2,
    WK_NONE  = 2'd3
  } wr_kind_e;

  // page-size codes carried per row
  localparam logic [1:0] PG_2K = 2'b00;
  localparam logic [1:0] PG_4K = 2'b01;
  localparam logic [1:0] PG_8K = 2'b10;
endpackage

// File: rtl/rbd_cfg_regs.sv
module rbd_cfg_regs
  import rbd_pkg::*;
#(
  parameter int ROWS  = 8,
  parameter int BND_W = 8,
  localparam int IDX_W  = $clog2(ROWS),
  localparam int PAGE_W = 2 * ROWS
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [1:0]                  wr_kind,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic [PAGE_W-1:0]           wr_data,
  output logic [ROWS-1:0][BND_W-1:0]  bnd_q,
  output logic [PAGE_W-1:0]           page_q,
  output logic [ROWS-1:0]             bank_q
);
  wr_kind_e kind;
  assign kind = wr_kind_e'(wr_kind);

  // one register per row, each with its own select
  for (genvar n = 0; n < ROWS; n++) begin : g_bnd
    always_ff @(posedge clk) begin
      if (rst)
        bnd_q[n] <= '0;
      else if (wr_en && kind == WK_BOUND && wr_idx == IDX_W'(n))
        bnd_q[n] <= wr_data[BND_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      page_q <= '0;
      bank_q <= '0;
    end else if (wr_en) begin
      if (kind == WK_PAGE) page_q <= wr_data;
      if (kind == WK_BANK) bank_q <= wr_data[ROWS-1:0];
    end
  end

  AST_BOUND_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_kind == 2'd0) |=> bnd_q[$past(wr_idx)] == $past(wr_data[BND_W-1:0])); // R1
  AST_NONE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_kind == 2'd3) |=> ($stable(bnd_q) && $stable(page_q) && $stable(bank_q))); // R8
  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (bnd_q == '0 && page_q == '0 && bank_q == '0)); // R7
endmodule

// File: rtl/rbd_row_select.sv
module rbd_row_select #(
  parameter int ROWS  = 8,
  parameter int BND_W = 8,
  parameter int AHI_W = 9,
  localparam int IDX_W = $clog2(ROWS),
  localparam int CMP_W = (AHI_W > BND_W) ? AHI_W : BND_W
) (
  input  logic [AHI_W-1:0]            addr_hi,
  input  logic [ROWS-1:0][BND_W-1:0]  bnd,
  output logic [IDX_W-1:0]            idx,
  output logic                        hit
);
  logic [CMP_W-1:0] a_ext;
  logic [ROWS-1:0]  below;

  assign a_ext = CMP_W'(addr_hi);

  // one comparator per row, all in parallel
  for (genvar n = 0; n < ROWS; n++) begin : g_cmp
    logic [CMP_W-1:0] b_ext;
    assign b_ext    = CMP_W'(bnd[n]);
    assign below[n] = a_ext < b_ext;
  end

  // lowest set bit wins; scan from the top so the lowest writes last
  always_comb begin
    idx = '0;
    for (int n = ROWS - 1; n >= 0; n--)
      if (below[n]) idx = IDX_W'(n);
  end

  assign hit = |below;
endmodule

// File: rtl/rbd_attr_mux.sv
module rbd_attr_mux #(
  parameter int ROWS = 8,
  localparam int IDX_W  = $clog2(ROWS),
  localparam int PAGE_W = 2 * ROWS
) (
  input  logic [IDX_W-1:0]  idx,
  input  logic              hit,
  input  logic [PAGE_W-1:0] page_word,
  input  logic [ROWS-1:0]   bank_bits,
  output logic [1:0]        page_code,
  output logic              bank_flag
);
  always_comb begin
    page_code = '0;
    bank_flag = 1'b0;
    if (hit) begin
      page_code = page_word[2*idx +: 2];
      bank_flag = bank_bits[idx];
    end
  end
endmodule

// File: rtl/row_bound_decode.sv
module row_bound_decode #(
  parameter int ROWS      = 8,
  parameter int BND_W     = 8,
  parameter int ADDR_W    = 32,
  parameter int GRAN_LOG2 = 23,
  localparam int IDX_W  = $clog2(ROWS),
  localparam int PAGE_W = 2 * ROWS,
  localparam int AHI_W  = ADDR_W - GRAN_LOG2,
  localparam int CMP_W  = (AHI_W > BND_W) ? AHI_W : BND_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [1:0]        wr_kind,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [PAGE_W-1:0] wr_data,
  output logic [IDX_W-1:0]  row_idx,
  output logic              row_hit,
  output logic [1:0]        page_code,
  output logic              bank_flag
);
  logic [ROWS-1:0][BND_W-1:0] bnd_q;
  logic [PAGE_W-1:0]          page_q;
  logic [ROWS-1:0]            bank_q;
  logic [AHI_W-1:0]           addr_hi;

  // only the granule number matters: boundaries have zero low bits
  assign addr_hi = addr[ADDR_W-1:GRAN_LOG2];

  rbd_cfg_regs #(.ROWS(ROWS), .BND_W(BND_W)) u_regs (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .wr_kind(wr_kind),
    .wr_idx (wr_idx),
    .wr_data(wr_data),
    .bnd_q  (bnd_q),
    .page_q (page_q),
    .bank_q (bank_q)
  );

  rbd_row_select #(.ROWS(ROWS), .BND_W(BND_W), .AHI_W(AHI_W)) u_sel (
    .addr_hi(addr_hi),
    .bnd    (bnd_q),
    .idx    (row_idx),
    .hit    (row_hit)
  );

  rbd_attr_mux #(.ROWS(ROWS)) u_attr (
    .idx      (row_idx),
    .hit      (row_hit),
    .page_word(page_q),
    .bank_bits(bank_q),
    .page_code(page_code),
    .bank_flag(bank_flag)
  );

  // boundary values seen by the checks below
  logic [CMP_W-1:0] a_cmp, sel_bnd, prev_bnd, last_bnd;
  always_comb begin
    a_cmp    = CMP_W'(addr_hi);
    sel_bnd  = CMP_W'(bnd_q[row_idx]);
    prev_bnd = (row_idx == '0) ? '0 : CMP_W'(bnd_q[row_idx - 1'b1]);
    last_bnd = CMP_W'(bnd_q[ROWS-1]);
  end

  AST_HIT_UNDER_END: assert property (@(posedge clk) disable iff (rst)
    row_hit |-> a_cmp < sel_bnd); // R2
  AST_NOT_BEFORE_PREV: assert property (@(posedge clk) disable iff (rst)
    row_hit |-> a_cmp >= prev_bnd); // R3
  AST_MISS_ZEROED: assert property (@(posedge clk) disable iff (rst)
    !row_hit |-> (row_idx == '0 && page_code == 2'b00 && !bank_flag)); // R4
  AST_MISS_PAST_LAST: assert property (@(posedge clk) disable iff (rst)
    !row_hit |-> a_cmp >= last_bnd); // R4
endmodule

// File: tb/sim_row_bound_decode.sv
module sim_row_bound_decode;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] addr = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_kind = '0;
  logic [2:0]  wr_idx = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  row_idx;
  logic        row_hit;
  logic [1:0]  page_code;
  logic        bank_flag;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  row_bound_decode u0 (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_kind(wr_kind),
    .wr_idx(wr_idx), .wr_data(wr_data), .row_idx(row_idx), .row_hit(row_hit),
    .page_code(page_code), .bank_flag(bank_flag)
  );

  // layout: 16MB, empty, 32MB, 8MB, empty, 64MB, 128MB, empty
  localparam logic [7:0] BND [8] = '{8'd2, 8'd2, 8'd6, 8'd7, 8'd7, 8'd15, 8'd31, 8'd31};
  localparam logic [15:0] PAGE_CFG = 16'h192D;
  localparam logic [7:0]  BANK_CFG = 8'h65;

  // {addr, hit, row}
  localparam int NV = 12;
  localparam logic [35:0] VEC [NV] = '{
    {32'h0000_0000, 1'b1, 3'd0},
    {32'h00FF_FFFF, 1'b1, 3'd0},
    {32'h0100_0000, 1'b1, 3'd2},
    {32'h02FF_FFFF, 1'b1, 3'd2},
    {32'h0300_0000, 1'b1, 3'd3},
    {32'h037F_FFFF, 1'b1, 3'd3},
    {32'h0380_0000, 1'b1, 3'd5},
    {32'h077F_FFFF, 1'b1, 3'd5},
    {32'h0780_0000, 1'b1, 3'd6},
    {32'h0F7F_FFFF, 1'b1, 3'd6},
    {32'h0F80_0000, 1'b0, 3'd0},
    {32'hFFFF_FFFF, 1'b0, 3'd0}
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic do_write(input logic [1:0] k, input logic [2:0] i, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_kind = k; wr_idx = i; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic check_all(input string req, input logic eh, input logic [2:0] er);
    logic [1:0] ep;
    logic       eb;
    ep = eh ? PAGE_CFG[2*er +: 2] : 2'b00;
    eb = eh ? BANK_CFG[er] : 1'b0;
    chk({req, " hit"},  32'(row_hit),   32'(eh));
    chk({req, " row"},  32'(row_idx),   32'(er));
    chk({req, " page"}, 32'(page_code), 32'(ep));
    chk({req, " bank"}, 32'(bank_flag), 32'(eb));
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R7: reset state, all registers empty so everything misses
    addr = 32'h0000_0000; #1;
    chk("R7 miss after reset", 32'(row_hit), 32'd0);
    chk("R7 row after reset", 32'(row_idx), 32'd0);

    // R7/R5: default page code 2KB on a freshly populated row
    do_write(2'd0, 3'd0, 16'd1);
    #1;
    chk("R7 default hit", 32'(row_hit), 32'd1);
    chk("R5 default page 2KB", 32'(page_code), 32'd0);
    chk("R6 default bank", 32'(bank_flag), 32'd0);

    // load the full layout (R1, R5, R6)
    for (int n = 0; n < 8; n++) do_write(2'd0, 3'(n), {8'd0, BND[n]});
    do_write(2'd1, 3'd0, PAGE_CFG);
    do_write(2'd2, 3'd0, {8'd0, BANK_CFG});

    // R2/R3/R4/R5/R6/R9: sweep, address only, no clock edges between vectors
    for (int v = 0; v < NV; v++) begin
      addr = VEC[v][35:4];
      #1;
      if (VEC[v][3]) check_all($sformatf("R2 R3 vec%0d", v), 1'b1, VEC[v][2:0]);
      else           check_all($sformatf("R4 vec%0d", v), 1'b0, 3'd0);
    end

    // R9/R10/R1: write lands only at the capturing edge
    addr = 32'h7F00_0000;
    @(negedge clk);
    wr_en = 1'b1; wr_kind = 2'd0; wr_idx = 3'd7; wr_data = 16'd255;
    #1;
    chk("R9 before edge still miss", 32'(row_hit), 32'd0);
    @(posedge clk); #1;
    chk("R1 R9 after edge hit", 32'(row_hit), 32'd1);
    chk("R10 row7 at 254", 32'(row_idx), 32'd7);
    @(negedge clk) wr_en = 1'b0;
    addr = 32'h7F80_0000; #1;
    chk("R10 miss at 255", 32'(row_hit), 32'd0);

    // R8: write with kind 3 changes nothing
    addr = 32'h7F00_0000;
    do_write(2'd3, 3'd7, 16'h0000);
    #1;
    check_all("R8 after ignored write", 1'b1, 3'd7);
    addr = 32'h0000_0000; #1;
    check_all("R8 row0 intact", 1'b1, 3'd0);

    // R5: rewrite page word, row 6 takes code 10 (8KB)
    do_write(2'd1, 3'd0, 16'h2000);
    addr = 32'h0800_0000; #1;
    chk("R5 row6 8KB", 32'(page_code), 32'd2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule